// File: doc/BRIEF.md
# Single-Cycle 16-bit Processor Core

This block is a small processor that completes one 16-bit instruction on every clock edge. A 16-bit program counter drives the fetch port of a shared word memory. A second read port of the same memory, with the single write port beside it, serves loads and stores in the same cycle. The core also holds a register file of eight codes: code 000 always reads zero, codes 001 to 100 are general registers, and codes 101 to 111 have no storage. It also contains a four-function ALU, a three-way write-back selector and an instruction decoder.

Instruction fields are fixed. The opcode sits in bits 15:12, the destination (or store data) register in bits 10:8, the first operand (or memory address) register in bits 6:4, the second operand register in bits 2:0, and the immediate byte in bits 7:0. Bits 11, 7 and 3 are reserved. The defined opcodes are:

- 0000: load-immediate (`rd := imm8`, zero-extended).
- 0100: store (`mem[ra] := rd`).
- 0101: load (`rd := mem[ra]`).
- 10ff: ALU operation (`rd := ra op rb`), where ff = 00 add, 01 subtract, 10 and, 11 xor.

Memory addresses use the low bits of a register value. A backdoor port lets a testbench fill memory and read it back while the core is held in reset.

Top module: `cpu16_core`

## Requirements
- R1: While reset is high the program counter reads 0. After reset every general register reads zero.
- R2: Each clock edge out of reset increments the program counter by one, modulo 2^16.
- R3: Opcode 0000 writes the instruction's low byte, zero-extended, into rd. For example, 0x02AB leaves register 2 at 0x00AB.
- R4: Opcodes 1000, 1001, 1010 and 1011 write ra+rb, ra-rb, ra&rb and ra^rb into rd, modulo 2^16, with no flags.
- R5: Opcode 0101 writes the memory word at the address held in ra into rd.
- R6: Opcode 0100 writes rd into the memory word addressed by ra on the clock edge, and writes no register.
- R7: Register code 000 reads zero, even after an instruction writes to it.
- R8: Register codes 101 to 111 read zero and ignore writes.
- R9: The program 0x0109, 0x0201, 0x5310, 0x8332, 0x4310 at address 0, with word 9 preset to 0x00FF, leaves word 9 at 0x00FF after four instructions and at 0x0100 after five.
- R10: Any opcode other than 0000, 0100, 0101 and 10xx changes no register and no memory word.
- R11: Reserved instruction bits 11, 7 and 3 do not affect execution.
- R12: While reset is high the core stores nothing to memory and the program counter stays at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| bd_we | input | 1 | Backdoor write strobe (use only while in reset) |
| bd_addr | input | 16 | Backdoor word address (low bits used) |
| bd_wdata | input | 16 | Backdoor write data |
| bd_rdata | output | 16 | Memory word at bd_addr |
| pc_o | output | 16 | Current program counter |

## Verification
Register state can only be seen through stores, so each test program ends by storing the register under test and the bench reads the word back. A wrong register value therefore shows at the backdoor port one instruction after the store, and never earlier. A wrong program counter shows at once on pc_o. It also shows indirectly, because the wrong instruction is fetched and the stored results are corrupted. A decoder that lets an undefined opcode act shows in the same run as a clobbered source register or a rewritten sentinel word.

// File: rtl/cpu16_pkg.sv
package cpu16_pkg;
  localparam int XLEN     = 16;
  localparam int REG_SELW = 3;
  localparam int IMM_W    = 8;

  localparam logic [3:0] OPC_MOVL   = 4'b0000;
  localparam logic [3:0] OPC_STORE  = 4'b0100;
  localparam logic [3:0] OPC_LOAD   = 4'b0101;
  localparam logic [1:0] OPC_ALU_HI = 2'b10;

  typedef enum logic [1:0] {
    ALU_ADD = 2'b00,
    ALU_SUB = 2'b01,
    ALU_AND = 2'b10,
    ALU_XOR = 2'b11
  } alu_fn_e;

  typedef enum logic [1:0] {
    WB_ALU = 2'b00,
    WB_MEM = 2'b01,
    WB_IMM = 2'b10
  } wb_src_e;

  typedef struct packed {
    logic [REG_SELW-1:0] rs1;
    logic [REG_SELW-1:0] rs2;
    logic [REG_SELW-1:0] ws;
    logic                rf_we;
    logic                st;
    logic                ld;
    wb_src_e             wb;
    alu_fn_e             fn;
    logic [XLEN-1:0]     imm;
  } ctrl_t;
endpackage

// File: rtl/cpu16_decode.sv
module cpu16_decode
  import cpu16_pkg::*;
(
  input  logic [XLEN-1:0] instr,
  output ctrl_t           ctl
);
  logic [3:0]          op;
  logic [REG_SELW-1:0] f_rd, f_ra, f_rb;
  logic                unused_rsv;

  assign op         = instr[15:12];
  assign f_rd       = instr[10:8];
  assign f_ra       = instr[6:4];
  assign f_rb       = instr[2:0];
  assign unused_rsv = ^{instr[11], instr[7], instr[3]};

  always_comb begin
    ctl       = '0;
    ctl.rs1   = f_ra;
    ctl.rs2   = f_rb;
    ctl.ws    = f_rd;
    ctl.wb    = WB_ALU;
    ctl.fn    = ALU_ADD;
    ctl.imm   = {{(XLEN-IMM_W){1'b0}}, instr[IMM_W-1:0]};
    if (op[3:2] == OPC_ALU_HI) begin
      ctl.rf_we = 1'b1;
      ctl.wb    = WB_ALU;
      ctl.fn    = alu_fn_e'(op[1:0]);
    end else begin
      case (op)
        OPC_MOVL: begin
          ctl.rf_we = 1'b1;
          ctl.wb    = WB_IMM;
        end
        OPC_STORE: begin
          ctl.st  = 1'b1;
          ctl.rs2 = f_rd;
        end
        OPC_LOAD: begin
          ctl.ld    = 1'b1;
          ctl.rf_we = 1'b1;
          ctl.wb    = WB_MEM;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cpu16_alu.sv
module cpu16_alu
  import cpu16_pkg::*;
#(
  parameter int W = XLEN
) (
  input  alu_fn_e      fn,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    case (fn)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_XOR: y = a ^ b;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/cpu16_regfile.sv
module cpu16_regfile #(
  parameter int W    = 16,
  parameter int SELW = 3,
  parameter int NGPR = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [SELW-1:0] waddr,
  input  logic [W-1:0]    wdata,
  input  logic [SELW-1:0] raddr_a,
  output logic [W-1:0]    rdata_a,
  input  logic [SELW-1:0] raddr_b,
  output logic [W-1:0]    rdata_b
);
  localparam int NCODES = 1 << SELW;

  logic [NCODES-1:0][W-1:0] bank;

  for (genvar i = 0; i < NCODES; i++) begin : g_code
    if (i >= 1 && i <= NGPR) begin : g_store
      logic [W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst)                                     q <= '0;
        else if (we && waddr == SELW'(i))            q <= wdata;
      end
      assign bank[i] = q;
    end else begin : g_zero
      assign bank[i] = '0;
    end
  end

  assign rdata_a = bank[raddr_a];
  assign rdata_b = bank[raddr_b];
endmodule

// File: rtl/cpu16_mem.sv
module cpu16_mem #(
  parameter int W     = 16,
  parameter int DEPTH = 256,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [AW-1:0]           waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NRD-1:0][AW-1:0]  raddr,
  output logic [NRD-1:0][W-1:0]   rdata
);
  logic [W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = ram[raddr[p]];
  end
endmodule

// File: rtl/cpu16_core.sv
module cpu16_core
  import cpu16_pkg::*;
#(
  parameter int MEM_DEPTH = 256,
  parameter int NUM_GPR   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            bd_we,
  input  logic [XLEN-1:0] bd_addr,
  input  logic [XLEN-1:0] bd_wdata,
  output logic [XLEN-1:0] bd_rdata,
  output logic [XLEN-1:0] pc_o
);
  localparam int AW       = $clog2(MEM_DEPTH);
  localparam int NRD      = 3;
  localparam int RP_FETCH = 0;
  localparam int RP_DATA  = 1;
  localparam int RP_BD    = 2;

  logic [XLEN-1:0] pc_q;
  logic [XLEN-1:0] instr;
  ctrl_t           ctl;
  logic [XLEN-1:0] ra_val, rb_val, alu_y, dmem_rdata, wb_data;
  logic            st_en;

  logic                    mem_we;
  logic [AW-1:0]           mem_waddr;
  logic [XLEN-1:0]         mem_wdata;
  logic [NRD-1:0][AW-1:0]  mem_raddr;
  logic [NRD-1:0][XLEN-1:0] mem_rdata;
  logic                    unused_hi;

  // program counter
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_q + XLEN'(1);
  end
  assign pc_o = pc_q;

  // shared memory: fetch, data and backdoor read ports, one write port
  assign mem_raddr[RP_FETCH] = pc_q[AW-1:0];
  assign mem_raddr[RP_DATA]  = ra_val[AW-1:0];
  assign mem_raddr[RP_BD]    = bd_addr[AW-1:0];
  assign instr      = mem_rdata[RP_FETCH];
  assign dmem_rdata = mem_rdata[RP_DATA];
  assign bd_rdata   = mem_rdata[RP_BD];

  assign st_en     = ctl.st & ~rst;
  assign mem_we    = bd_we | st_en;
  assign mem_waddr = bd_we ? bd_addr[AW-1:0] : ra_val[AW-1:0];
  assign mem_wdata = bd_we ? bd_wdata : rb_val;
  assign unused_hi = ^{bd_addr[XLEN-1:AW], ra_val[XLEN-1:AW], pc_q[XLEN-1:AW]};

  cpu16_mem #(
    .W     (XLEN),
    .DEPTH (MEM_DEPTH),
    .NRD   (NRD)
  ) mem_i (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  cpu16_decode dec_i (
    .instr (instr),
    .ctl   (ctl)
  );

  cpu16_regfile #(
    .W    (XLEN),
    .SELW (REG_SELW),
    .NGPR (NUM_GPR)
  ) rf_i (
    .clk     (clk),
    .rst     (rst),
    .we      (ctl.rf_we),
    .waddr   (ctl.ws),
    .wdata   (wb_data),
    .raddr_a (ctl.rs1),
    .rdata_a (ra_val),
    .raddr_b (ctl.rs2),
    .rdata_b (rb_val)
  );

  cpu16_alu #(.W(XLEN)) alu_i (
    .fn (ctl.fn),
    .a  (ra_val),
    .b  (rb_val),
    .y  (alu_y)
  );

  // write-back selection
  always_comb begin
    case (ctl.wb)
      WB_ALU:  wb_data = alu_y;
      WB_MEM:  wb_data = dmem_rdata;
      WB_IMM:  wb_data = ctl.imm;
      default: wb_data = '0;
    endcase
  end
endmodule

// File: rtl/cpu16_core_chk.sv
module cpu16_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [15:0] pc,
  input logic [15:0] instr,
  input logic        rf_we,
  input logic        ld,
  input logic        st_en,
  input logic [15:0] wb_data,
  input logic [15:0] dmem_rdata
);
  logic       rst_q;
  logic [3:0] opc;
  logic       legal;

  always_ff @(posedge clk) rst_q <= rst;

  assign opc   = instr[15:12];
  assign legal = (opc == 4'b0000) || (opc == 4'b0100) || (opc == 4'b0101) || (opc[3:2] == 2'b10);

  AST_PC_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    rst_q |-> (pc == 16'h0000)); // R1

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (pc == $past(pc) + 16'd1)); // R2

  AST_MOVL_ZEXT: assert property (@(posedge clk) disable iff (rst)
    (rf_we && opc == 4'b0000) |-> (wb_data == {8'h00, instr[7:0]})); // R3

  AST_LOAD_PATH: assert property (@(posedge clk) disable iff (rst)
    (ld && rf_we) |-> (wb_data == dmem_rdata)); // R5

  AST_STORE_NO_WB: assert property (@(posedge clk) disable iff (rst)
    st_en |-> !rf_we); // R6

  AST_ILLEGAL_NOP: assert property (@(posedge clk) disable iff (rst)
    !legal |-> (!rf_we && !st_en)); // R10
endmodule

bind cpu16_core cpu16_core_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .pc         (pc_q),
  .instr      (instr),
  .rf_we      (ctl.rf_we),
  .ld         (ctl.ld),
  .st_en      (st_en),
  .wb_data    (wb_data),
  .dmem_rdata (dmem_rdata)
);

// File: tb/cpu16_core_tb.sv
module cpu16_core_tb_top;
  localparam int CLK_PERIOD   = 10;
  localparam int WATCHDOG_CYC = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bd_we = 1'b0;
  logic [15:0] bd_addr = '0;
  logic [15:0] bd_wdata = '0;
  wire  [15:0] bd_rdata;
  wire  [15:0] pc_o;

  int n_chk = 0;
  int n_err = 0;
  logic [15:0] prog [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu16_core dut_i (
    .clk      (clk),
    .rst      (rst),
    .bd_we    (bd_we),
    .bd_addr  (bd_addr),
    .bd_wdata (bd_wdata),
    .bd_rdata (bd_rdata),
    .pc_o     (pc_o)
  );

  function automatic logic [15:0] enc_i(input logic [2:0] rd, input logic [7:0] imm);
    return {4'h0, 1'b0, rd, imm};
  endfunction

  function automatic logic [15:0] enc_r(input logic [3:0] op, input logic [2:0] rd,
                                        input logic [2:0] ra, input logic [2:0] rb);
    return {op, 1'b0, rd, 1'b0, ra, 1'b0, rb};
  endfunction

  function automatic logic [15:0] alu_ref(input int op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      0:       return a + b;
      1:       return a - b;
      2:       return a & b;
      default: return a ^ b;
    endcase
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [15:0] addr, input logic [15:0] data);
    @(negedge clk);
    bd_we = 1'b1; bd_addr = addr; bd_wdata = data;
    @(negedge clk);
    bd_we = 1'b0;
  endtask

  task automatic peek(input logic [15:0] addr, output logic [15:0] data);
    bd_addr = addr;
    #1;
    data = bd_rdata;
  endtask

  task automatic load_prog(input int n);
    for (int i = 0; i < n; i++) poke(16'(i), prog[i]);
  endtask

  task automatic run(input int n);
    @(negedge clk);
    rst = 1'b0;
    repeat (n) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    logic [15:0] a, b, e, w;
    logic [2:0]  ar;
    logic [7:0]  imm;

    // R1 / R12: reset holds pc, stores are suppressed
    repeat (3) @(negedge clk);
    check("R1 pc in reset", pc_o, 16'h0000);
    poke(16'h0000, 16'h4000);            // store rz to [rz]
    repeat (3) @(negedge clk);
    peek(16'h0000, d);
    check("R12 no store in reset", d, 16'h4000);
    check("R12 pc held in reset", pc_o, 16'h0000);
    rst = 1'b0;
    @(negedge clk);
    peek(16'h0000, d);
    check("R6 store executes", d, 16'h0000);
    check("R2 pc after one step", pc_o, 16'h0001);
    rst = 1'b1;
    @(negedge clk);

    // R9: worked example with pc trace
    prog[0] = 16'h0109; prog[1] = 16'h0201; prog[2] = 16'h5310;
    prog[3] = 16'h8332; prog[4] = 16'h4310;
    load_prog(5);
    for (int i = 5; i < 9; i++) poke(16'(i), 16'h0000);
    poke(16'h0009, 16'h00FF);
    @(negedge clk);
    rst = 1'b0;
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk);
      check($sformatf("R2 pc step %0d", k), pc_o, 16'(k));
      if (k == 4) begin peek(16'h0009, d); check("R9 word9 before store", d, 16'h00FF); end
      if (k == 5) begin peek(16'h0009, d); check("R9 word9 after store", d, 16'h0100); end
    end
    rst = 1'b1;
    @(negedge clk);

    // R3 / R7 / R8: load-immediate to every register code
    for (int rd = 0; rd < 8; rd++) begin
      ar  = (rd == 1) ? 3'd2 : 3'd1;
      imm = 8'hA5 ^ 8'(rd * 19);
      prog[0] = enc_i(3'(rd), imm);
      prog[1] = enc_i(ar, 8'h90);
      prog[2] = enc_r(4'h4, 3'(rd), ar, 3'd0);
      load_prog(3);
      poke(16'h0090, 16'hFFFF);
      run(3);
      peek(16'h0090, d);
      if (rd == 0)      check("R7 zero register", d, 16'h0000);
      else if (rd > 4)  check($sformatf("R8 code %0d", rd), d, 16'h0000);
      else              check($sformatf("R3 movl r%0d", rd), d, {8'h00, imm});
    end
    prog[0] = 16'h02AB;
    prog[1] = enc_i(3'd1, 8'h91);
    prog[2] = enc_r(4'h4, 3'd2, 3'd1, 3'd0);
    load_prog(3);
    poke(16'h0091, 16'hFFFF);
    run(3);
    peek(16'h0091, d);
    check("R3 0x02AB zero-extend", d, 16'h00AB);

    // R4 / R11: ALU sweep with loaded 16-bit operands
    for (int op = 0; op < 4; op++) begin
      for (int i = 0; i < 12; i++) begin
        if (i == 0)      begin a = 16'hFFFF; b = 16'h0001; end
        else if (i == 1) begin a = 16'h0000; b = 16'h0001; end
        else begin
          a = 16'(i * 16'h1D87 + 16'h0F0F);
          b = 16'(i * 16'h3A5B) ^ 16'hC3C3;
        end
        e = alu_ref(op, a, b);
        w = enc_r({2'b10, 2'(op)}, 3'd3, 3'd1, 3'd2);
        if (i % 2 == 1) w = w | 16'h0888;
        prog[0] = enc_i(3'd4, 8'h80);
        prog[1] = enc_r(4'h5, 3'd1, 3'd4, 3'd0);
        prog[2] = enc_i(3'd4, 8'h81);
        prog[3] = enc_r(4'h5, 3'd2, 3'd4, 3'd0);
        prog[4] = w;
        prog[5] = enc_i(3'd4, 8'h82);
        prog[6] = enc_r(4'h4, 3'd3, 3'd4, 3'd0);
        load_prog(7);
        poke(16'h0080, a);
        poke(16'h0081, b);
        poke(16'h0082, ~e);
        run(7);
        peek(16'h0082, d);
        check($sformatf("%s op%0d a=%h b=%h", (i % 2 == 1) ? "R4 R11" : "R4", op, a, b), d, e);
      end
    end

    // R5: load then store back
    prog[0] = enc_i(3'd4, 8'h85);
    prog[1] = enc_r(4'h5, 3'd2, 3'd4, 3'd0);
    prog[2] = enc_i(3'd4, 8'h86);
    prog[3] = enc_r(4'h4, 3'd2, 3'd4, 3'd0);
    load_prog(4);
    poke(16'h0085, 16'hBEEF);
    poke(16'h0086, 16'h0000);
    run(4);
    peek(16'h0086, d);
    check("R5 load word", d, 16'hBEEF);

    // R6: store leaves its data register intact
    prog[0] = enc_i(3'd1, 8'h33);
    prog[1] = enc_i(3'd4, 8'h87);
    prog[2] = enc_r(4'h4, 3'd1, 3'd4, 3'd0);
    prog[3] = enc_i(3'd4, 8'h88);
    prog[4] = enc_r(4'h4, 3'd1, 3'd4, 3'd0);
    load_prog(5);
    poke(16'h0087, 16'h0000);
    poke(16'h0088, 16'h0000);
    run(5);
    peek(16'h0087, d);
    check("R6 first store", d, 16'h0033);
    peek(16'h0088, d);
    check("R6 no register write", d, 16'h0033);

    // R10: undefined opcodes act as no-ops
    for (int op = 0; op < 16; op++) begin
      if (op == 0 || op == 4 || op == 5 || (op >= 8 && op <= 11)) continue;
      prog[0] = enc_i(3'd1, 8'h55);
      prog[1] = enc_i(3'd2, 8'hA0);
      prog[2] = enc_i(3'd3, 8'hA1);
      prog[3] = enc_r(4'(op), 3'd1, 3'd3, 3'd1);
      prog[4] = enc_r(4'h4, 3'd1, 3'd2, 3'd0);
      load_prog(5);
      poke(16'h00A0, 16'h0000);
      poke(16'h00A1, 16'h1234);
      run(5);
      peek(16'h00A0, d);
      check($sformatf("R10 op%0d reg kept", op), d, 16'h0055);
      peek(16'h00A1, d);
      check($sformatf("R10 op%0d mem kept", op), d, 16'h1234);
    end

    // R1: reset clears dirtied registers
    prog[0] = enc_i(3'd1, 8'h11);
    prog[1] = enc_i(3'd2, 8'h22);
    prog[2] = enc_i(3'd3, 8'h33);
    prog[3] = enc_i(3'd4, 8'h44);
    load_prog(4);
    run(4);
    prog[0] = enc_r(4'h4, 3'd1, 3'd0, 3'd0);
    prog[1] = enc_i(3'd1, 8'h41);
    prog[2] = enc_r(4'h4, 3'd2, 3'd1, 3'd0);
    prog[3] = enc_i(3'd1, 8'h42);
    prog[4] = enc_r(4'h4, 3'd3, 3'd1, 3'd0);
    prog[5] = enc_i(3'd1, 8'h43);
    prog[6] = enc_r(4'h4, 3'd4, 3'd1, 3'd0);
    load_prog(7);
    for (int i = 0; i < 3; i++) poke(16'h0041 + 16'(i), 16'hDEAD);
    run(7);
    peek(16'h0000, d);
    check("R1 r1 cleared", d, 16'h0000);
    for (int i = 0; i < 3; i++) begin
      peek(16'h0041 + 16'(i), d);
      check($sformatf("R1 r%0d cleared", i + 2), d, 16'h0000);
    end

    finish_run();
  end
endmodule